// File: doc/BRIEF.md
# Page Access Rights and Fault Code Unit

This unit takes the result of a finished page-table walk and decides what the access may do. Its inputs are the effective page attributes gathered along the walk (user, writable, no-execute), the leaf entry, the kind of access, the privilege of the requester and a set of mode controls. From these it works out the read/write/execute rights of the page and either grants the access or returns a page-fault error code together with the faulting virtual address. Supervisor access prevention, supervisor execute prevention, write protection and per-key access or write disable all feed into the decision.

A fault found by the walker itself (entry absent, reserved bits set) goes into the same unit and is encoded in the same error-code format, so the core sees one fault path. The decision logic is combinational. A parameter chooses whether the response is registered (one cycle of latency, the default) or passed through in the same cycle.

Top module: `pgperm_unit`

## Requirements
- R1: An access with `is_user`=1 to a page whose `attr_user`=0 faults with the protection bit (error-code bit 0) set, whatever the other attributes are.
- R2: Read right is present unless `smap_on`=1, `is_user`=0 and `attr_user`=1; a load is granted only with the read right.
- R3: Write right needs the read right and also either `attr_rw`=1 or a supervisor access with `wp_on`=0; a store without it faults with error code bits P and W.
- R4: Execute right is present when `attr_nx`=0 and either `is_user`=1 or not (`smep_on`=1 and `attr_user`=1).
- R5: The key register is `ukey_reg` when `attr_user`=1 and `pke_on`=1, `skey_reg` when `attr_user`=0 and `pks_on`=1, and otherwise zero; a zero key register applies no key rule.
- R6: The key index is `leaf_pte[62:59]`. Key register bit 2k disables read and write for key k. Bit 2k+1 disables write only, and only when `is_user`=1 or `wp_on`=1.
- R7: An access refused by the key rule faults with both error-code bit 5 (key) and bit 0 (protection); a fetch never faults this way because the key rule never removes execute.
- R8: `walk_fault` codes 0=none, 1=entry absent, 2 or 3=reserved bit. A walker fault wins over every rights check; absent leaves bits 0 and 3 clear, reserved sets bit 3 and clears bit 0.
- R9: Every fault code carries bit 2 for user accesses, bit 1 for stores, and bit 4 for fetches only when `nxe_on`=1 or `smep_on`=1.
- R10: On a fault `rsp_fault_addr` equals the request's `vaddr`; on a grant it is zero.
- R11: With `OUT_REG`=1 each response appears exactly one cycle after its request, `rsp_valid` follows `req_valid`, and reset clears `rsp_valid`.
- R12: Access codes are load=0, store=1, fetch=2. On a grant `rsp_prot` holds the final rights (bit 0 read, bit 1 write, bit 2 execute) with key limits applied, and `rsp_grant`/`rsp_fault` are exclusive. On a fault `rsp_prot` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| acc_type | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| is_user | input | 1 | Requester runs at user privilege |
| smap_on | input | 1 | Supervisor access to user pages is blocked |
| wp_on | input | 1 | Write protection applies to supervisor |
| smep_on | input | 1 | Supervisor execute of user pages is blocked |
| nxe_on | input | 1 | No-execute feature enabled |
| pke_on | input | 1 | User-page key checks enabled |
| pks_on | input | 1 | Supervisor-page key checks enabled |
| attr_user | input | 1 | Effective user attribute of the page |
| attr_rw | input | 1 | Effective writable attribute of the page |
| attr_nx | input | 1 | Effective no-execute attribute of the page |
| leaf_pte | input | PTE_W | Leaf entry; key index in bits 62:59 |
| walk_fault | input | 2 | Walker result: 0 none, 1 absent, 2/3 reserved |
| vaddr | input | VA_W | Virtual address of the access |
| ukey_reg | input | KEY_REG_W | Key rights register for user pages |
| skey_reg | input | KEY_REG_W | Key rights register for supervisor pages |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access granted |
| rsp_fault | output | 1 | Page fault raised |
| rsp_prot | output | 3 | Granted rights: bit 0 read, 1 write, 2 execute |
| rsp_ecode | output | 6 | Error code: 0 P, 1 W, 2 U, 3 RSVD, 4 I/D, 5 key |
| rsp_fault_addr | output | VA_W | Faulting virtual address |

## Verification
With the default registered output, every result (grant, rights, error code, address) belongs to the request presented one rising edge earlier. The bench drives a request on a falling edge and puts the expected response into a queue. A monitor samples the outputs on each later falling edge. Whenever `rsp_valid` is high it pops exactly one entry, so a response that arrives a cycle early or late shows up as a mismatch or as an empty or non-empty queue. Idle cycles are checked for a low `rsp_valid`.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_SPARE = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        WF_NONE   = 2'd0,
        WF_ABSENT = 2'd1,
        WF_RSVD   = 2'd2,
        WF_RSVD2  = 2'd3
    } wfault_e;

    typedef enum logic [2:0] {
        FK_NONE   = 3'd0,
        FK_ABSENT = 3'd1,
        FK_RSVD   = 3'd2,
        FK_PROT   = 3'd3,
        FK_KEY    = 3'd4
    } fkind_e;

    localparam int EC_W      = 6;
    localparam int EC_P      = 0;
    localparam int EC_WR     = 1;
    localparam int EC_USR    = 2;
    localparam int EC_RSV    = 3;
    localparam int EC_ID     = 4;
    localparam int EC_KEY    = 5;

    localparam int RT_W      = 3;
    localparam int RT_RD     = 0;
    localparam int RT_WR     = 1;
    localparam int RT_EX     = 2;

    typedef struct packed {
        logic wp;
        logic smep;
        logic nxe;
        logic pke;
        logic pks;
    } mode_t;

    typedef struct packed {
        logic usr;
        logic rw;
        logic nx;
    } attr_t;

    typedef struct packed {
        logic             valid;
        logic             grant;
        logic             fault;
        logic [RT_W-1:0]  prot;
        logic [EC_W-1:0]  ecode;
    } resp_t;

    // Does a rights vector permit the given access kind?
    function automatic logic rights_allow(input logic [RT_W-1:0] r, input acc_e a);
        case (a)
            ACC_STORE: rights_allow = r[RT_WR];
            ACC_FETCH: rights_allow = r[RT_EX];
            default:   rights_allow = r[RT_RD];
        endcase
    endfunction

endpackage

// File: rtl/pgperm_rights.sv
module pgperm_rights
    import pgperm_pkg::*;
(
    input  logic            is_user,
    input  logic            smap_on,
    input  mode_t           mode,
    input  attr_t           attr,
    output logic [RT_W-1:0] rights,
    output logic            user_viol
);
    logic rd_ok;
    logic wr_ok;
    logic ex_ok;

    always_comb begin
        user_viol = is_user && !attr.usr;
        rd_ok     = !(smap_on && !is_user && attr.usr);
        wr_ok     = rd_ok && (attr.rw || !(is_user || mode.wp));
        ex_ok     = !attr.nx && (is_user || !(mode.smep && attr.usr));
        rights          = '0;
        rights[RT_RD]   = rd_ok;
        rights[RT_WR]   = wr_ok;
        rights[RT_EX]   = ex_ok;
    end

endmodule

// File: rtl/pgperm_keychk.sv
module pgperm_keychk
    import pgperm_pkg::*;
#(
    parameter int KEY_BITS  = 4,
    parameter int KEY_REG_W = 2 * (2 ** KEY_BITS)
)(
    input  logic                 attr_usr,
    input  logic                 is_user,
    input  logic                 wp_on,
    input  logic                 pke_on,
    input  logic                 pks_on,
    input  logic [KEY_REG_W-1:0] ukey_reg,
    input  logic [KEY_REG_W-1:0] skey_reg,
    input  logic [KEY_BITS-1:0]  key_idx,
    output logic                 key_active,
    output logic [RT_W-1:0]      key_rights
);
    localparam int NKEYS = 2 ** KEY_BITS;

    logic [KEY_REG_W-1:0] sel_reg;
    logic [NKEYS-1:0]     acc_dis;
    logic [NKEYS-1:0]     wr_dis;
    logic                 ad_bit;
    logic                 wd_bit;

    always_comb begin
        if (attr_usr) begin
            sel_reg = pke_on ? ukey_reg : '0;
        end else begin
            sel_reg = pks_on ? skey_reg : '0;
        end
    end

    genvar k;
    generate
        for (k = 0; k < NKEYS; k++) begin : g_key
            assign acc_dis[k] = sel_reg[2*k];
            assign wr_dis[k]  = sel_reg[2*k+1];
        end
    endgenerate

    assign ad_bit     = acc_dis[key_idx];
    assign wd_bit     = wr_dis[key_idx];
    assign key_active = |sel_reg;

    always_comb begin
        key_rights = '1;
        if (ad_bit) begin
            key_rights[RT_RD] = 1'b0;
            key_rights[RT_WR] = 1'b0;
        end else if (wd_bit && (is_user || wp_on)) begin
            key_rights[RT_WR] = 1'b0;
        end
    end

endmodule

// File: rtl/pgperm_errenc.sv
module pgperm_errenc
    import pgperm_pkg::*;
(
    input  fkind_e          kind,
    input  acc_e            acc,
    input  logic            is_user,
    input  logic            nxe_on,
    input  logic            smep_on,
    output logic [EC_W-1:0] ecode
);
    always_comb begin
        ecode = '0;
        case (kind)
            FK_RSVD: ecode[EC_RSV] = 1'b1;
            FK_PROT: ecode[EC_P]   = 1'b1;
            FK_KEY: begin
                ecode[EC_P]   = 1'b1;
                ecode[EC_KEY] = 1'b1;
            end
            default: ecode = '0;
        endcase
        if (kind != FK_NONE) begin
            ecode[EC_USR] = is_user;
            ecode[EC_WR]  = (acc == ACC_STORE);
            ecode[EC_ID]  = (acc == ACC_FETCH) && (nxe_on || smep_on);
        end
    end

endmodule

// File: rtl/pgperm_unit.sv
module pgperm_unit
    import pgperm_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PTE_W     = 64,
    parameter int KEY_LSB   = 59,
    parameter int KEY_BITS  = 4,
    parameter int KEY_REG_W = 32,
    parameter bit OUT_REG   = 1'b1
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           acc_type,
    input  logic                 is_user,
    input  logic                 smap_on,
    input  logic                 wp_on,
    input  logic                 smep_on,
    input  logic                 nxe_on,
    input  logic                 pke_on,
    input  logic                 pks_on,
    input  logic                 attr_user,
    input  logic                 attr_rw,
    input  logic                 attr_nx,
    input  logic [PTE_W-1:0]     leaf_pte,
    input  logic [1:0]           walk_fault,
    input  logic [VA_W-1:0]      vaddr,
    input  logic [KEY_REG_W-1:0] ukey_reg,
    input  logic [KEY_REG_W-1:0] skey_reg,
    output logic                 rsp_valid,
    output logic                 rsp_grant,
    output logic                 rsp_fault,
    output logic [2:0]           rsp_prot,
    output logic [5:0]           rsp_ecode,
    output logic [VA_W-1:0]      rsp_fault_addr
);
    localparam int KEY_MSB = KEY_LSB + KEY_BITS - 1;

    acc_e                acc;
    wfault_e             wf;
    mode_t               mode;
    attr_t               attr;
    logic [RT_W-1:0]     base_rights;
    logic                user_viol;
    logic                key_active;
    logic [RT_W-1:0]     key_rights;
    logic [RT_W-1:0]     final_rights;
    fkind_e              kind;
    logic [EC_W-1:0]     ecode;
    resp_t               resp_d;
    logic [VA_W-1:0]     addr_d;

    assign acc  = acc_e'(acc_type);
    assign wf   = wfault_e'(walk_fault);
    assign mode = '{wp: wp_on, smep: smep_on, nxe: nxe_on, pke: pke_on, pks: pks_on};
    assign attr = '{usr: attr_user, rw: attr_rw, nx: attr_nx};

    pgperm_rights u_rights (
        .is_user   (is_user),
        .smap_on   (smap_on),
        .mode      (mode),
        .attr      (attr),
        .rights    (base_rights),
        .user_viol (user_viol)
    );

    pgperm_keychk #(
        .KEY_BITS  (KEY_BITS),
        .KEY_REG_W (KEY_REG_W)
    ) u_keychk (
        .attr_usr   (attr_user),
        .is_user    (is_user),
        .wp_on      (wp_on),
        .pke_on     (pke_on),
        .pks_on     (pks_on),
        .ukey_reg   (ukey_reg),
        .skey_reg   (skey_reg),
        .key_idx    (leaf_pte[KEY_MSB:KEY_LSB]),
        .key_active (key_active),
        .key_rights (key_rights)
    );

    // Fault priority: walker result, privilege, key rule, final rights.
    always_comb begin
        final_rights = key_active ? (base_rights & key_rights) : base_rights;
        if (wf == WF_ABSENT) begin
            kind = FK_ABSENT;
        end else if (wf != WF_NONE) begin
            kind = FK_RSVD;
        end else if (user_viol) begin
            kind = FK_PROT;
        end else if (key_active && !rights_allow(key_rights, acc)) begin
            kind = FK_KEY;
        end else if (!rights_allow(final_rights, acc)) begin
            kind = FK_PROT;
        end else begin
            kind = FK_NONE;
        end
    end

    pgperm_errenc u_errenc (
        .kind    (kind),
        .acc     (acc),
        .is_user (is_user),
        .nxe_on  (nxe_on),
        .smep_on (smep_on),
        .ecode   (ecode)
    );

    always_comb begin
        resp_d.valid = req_valid;
        resp_d.grant = req_valid && (kind == FK_NONE);
        resp_d.fault = req_valid && (kind != FK_NONE);
        resp_d.prot  = (req_valid && kind == FK_NONE) ? final_rights : '0;
        resp_d.ecode = (req_valid && kind != FK_NONE) ? ecode : '0;
        addr_d       = (req_valid && kind != FK_NONE) ? vaddr : '0;
    end

    generate
        if (OUT_REG) begin : g_reg
            resp_t           resp_q;
            logic [VA_W-1:0] addr_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    resp_q <= '0;
                    addr_q <= '0;
                end else begin
                    resp_q <= resp_d;
                    addr_q <= addr_d;
                end
            end
            assign rsp_valid      = resp_q.valid;
            assign rsp_grant      = resp_q.grant;
            assign rsp_fault      = resp_q.fault;
            assign rsp_prot       = resp_q.prot;
            assign rsp_ecode      = resp_q.ecode;
            assign rsp_fault_addr = addr_q;
        end else begin : g_comb
            assign rsp_valid      = resp_d.valid;
            assign rsp_grant      = resp_d.grant;
            assign rsp_fault      = resp_d.fault;
            assign rsp_prot       = resp_d.prot;
            assign rsp_ecode      = resp_d.ecode;
            assign rsp_fault_addr = addr_d;
        end
    endgenerate

endmodule

// File: rtl/pgperm_unit_chk.sv
module pgperm_unit_chk #(
    parameter int VA_W    = 64,
    parameter bit OUT_REG = 1'b1
)(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [1:0]      acc_type,
    input logic            is_user,
    input logic [1:0]      walk_fault,
    input logic [VA_W-1:0] vaddr,
    input logic            rsp_valid,
    input logic            rsp_grant,
    input logic            rsp_fault,
    input logic [2:0]      rsp_prot,
    input logic [5:0]      rsp_ecode,
    input logic [VA_W-1:0] rsp_fault_addr
);
    // R12
    grant_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_grant ^ rsp_fault));

    // R7
    key_implies_prot_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault && rsp_ecode[5]) |-> rsp_ecode[0]);

    generate
        if (OUT_REG) begin : g_seq
            // R11
            valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
                rsp_valid == $past(req_valid));

            // R7
            no_fetch_key_fault_chk: assert property (@(posedge clk) disable iff (rst)
                (rsp_fault && rsp_ecode[5]) |-> ($past(acc_type) != 2'd2));

            // R10
            fault_addr_chk: assert property (@(posedge clk) disable iff (rst)
                rsp_fault |-> (rsp_fault_addr == $past(vaddr)));

            // R9
            store_wbit_chk: assert property (@(posedge clk) disable iff (rst)
                rsp_fault |-> (rsp_ecode[1] == ($past(acc_type) == 2'd1)));

            // R9
            user_ubit_chk: assert property (@(posedge clk) disable iff (rst)
                rsp_fault |-> (rsp_ecode[2] == $past(is_user)));

            // R8
            walk_wins_chk: assert property (@(posedge clk) disable iff (rst)
                (rsp_valid && $past(walk_fault) != 2'd0) |-> (rsp_fault && !rsp_ecode[0]));

            // R12
            grant_has_right_chk: assert property (@(posedge clk) disable iff (rst)
                rsp_grant |-> ((($past(acc_type) == 2'd1) && rsp_prot[1]) ||
                               (($past(acc_type) == 2'd2) && rsp_prot[2]) ||
                               (($past(acc_type) != 2'd1) && ($past(acc_type) != 2'd2) && rsp_prot[0])));
        end
    endgenerate

endmodule

bind pgperm_unit pgperm_unit_chk #(
    .VA_W    (VA_W),
    .OUT_REG (OUT_REG)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .acc_type       (acc_type),
    .is_user        (is_user),
    .walk_fault     (walk_fault),
    .vaddr          (vaddr),
    .rsp_valid      (rsp_valid),
    .rsp_grant      (rsp_grant),
    .rsp_fault      (rsp_fault),
    .rsp_prot       (rsp_prot),
    .rsp_ecode      (rsp_ecode),
    .rsp_fault_addr (rsp_fault_addr)
);

// File: tb/pgperm_unit_tb_top.sv
module pgperm_unit_tb_top;

    typedef struct {
        logic [1:0]  acc;
        logic        usr;
        logic        smap;
        logic        wp;
        logic        smep;
        logic        nxe;
        logic        pke;
        logic        pks;
        logic        a_usr;
        logic        a_rw;
        logic        a_nx;
        logic [3:0]  key;
        logic [1:0]  wf;
        logic [63:0] va;
        logic [31:0] ukey;
        logic [31:0] skey;
    } stim_t;

    typedef struct {
        logic        grant;
        logic [2:0]  prot;
        logic [5:0]  ec;
        logic [63:0] fa;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  acc_type = '0;
    logic        is_user = 1'b0, smap_on = 1'b0, wp_on = 1'b0, smep_on = 1'b0;
    logic        nxe_on = 1'b0, pke_on = 1'b0, pks_on = 1'b0;
    logic        attr_user = 1'b0, attr_rw = 1'b0, attr_nx = 1'b0;
    logic [63:0] leaf_pte = '0;
    logic [1:0]  walk_fault = '0;
    logic [63:0] vaddr = '0;
    logic [31:0] ukey_reg = '0, skey_reg = '0;
    logic        rsp_valid, rsp_grant, rsp_fault;
    logic [2:0]  rsp_prot;
    logic [5:0]  rsp_ecode;
    logic [63:0] rsp_fault_addr;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    pgperm_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .acc_type(acc_type),
        .is_user(is_user), .smap_on(smap_on), .wp_on(wp_on), .smep_on(smep_on),
        .nxe_on(nxe_on), .pke_on(pke_on), .pks_on(pks_on),
        .attr_user(attr_user), .attr_rw(attr_rw), .attr_nx(attr_nx),
        .leaf_pte(leaf_pte), .walk_fault(walk_fault), .vaddr(vaddr),
        .ukey_reg(ukey_reg), .skey_reg(skey_reg),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
        .rsp_prot(rsp_prot), .rsp_ecode(rsp_ecode), .rsp_fault_addr(rsp_fault_addr)
    );

    // Expected result, worked out from the requirement list.
    function automatic exp_t model(input stim_t s, input string tag);
        exp_t e;
        logic [2:0] r, kr;
        logic [31:0] kreg;
        logic [5:0] ec;
        int   kind;  // 0 grant, 1 absent, 2 rsvd, 3 prot, 4 key
        logic kact, need;
        r[0] = !(s.smap && !s.usr && s.a_usr);
        r[1] = r[0] && (s.a_rw || !(s.usr || s.wp));
        r[2] = !s.a_nx && (s.usr || !(s.smep && s.a_usr));
        kreg = s.a_usr ? (s.pke ? s.ukey : 32'd0) : (s.pks ? s.skey : 32'd0);
        kact = (kreg != 0);
        kr = 3'b111;
        if (kreg[2*s.key]) kr = 3'b100;
        else if (kreg[2*s.key+1] && (s.usr || s.wp)) kr = 3'b101;
        if (kact) r = r & kr;
        if (s.wf == 2'd1) kind = 1;
        else if (s.wf != 2'd0) kind = 2;
        else if (s.usr && !s.a_usr) kind = 3;
        else begin
            need = (s.acc == 2'd1) ? kr[1] : (s.acc == 2'd2) ? kr[2] : kr[0];
            if (kact && !need) kind = 4;
            else begin
                need = (s.acc == 2'd1) ? r[1] : (s.acc == 2'd2) ? r[2] : r[0];
                kind = need ? 0 : 3;
            end
        end
        ec = '0;
        if (kind != 0) begin
            if (kind == 2) ec[3] = 1'b1;
            if (kind == 3) ec[0] = 1'b1;
            if (kind == 4) begin ec[0] = 1'b1; ec[5] = 1'b1; end
            ec[2] = s.usr;
            ec[1] = (s.acc == 2'd1);
            ec[4] = (s.acc == 2'd2) && (s.nxe || s.smep);
        end
        e.grant = (kind == 0);
        e.prot  = (kind == 0) ? r : 3'b000;
        e.ec    = ec;
        e.fa    = (kind == 0) ? 64'd0 : s.va;
        e.tag   = tag;
        return e;
    endfunction

    task automatic send(input stim_t s, input string tag);
        @(negedge clk);
        acc_type = s.acc; is_user = s.usr; smap_on = s.smap; wp_on = s.wp;
        smep_on = s.smep; nxe_on = s.nxe; pke_on = s.pke; pks_on = s.pks;
        attr_user = s.a_usr; attr_rw = s.a_rw; attr_nx = s.a_nx;
        leaf_pte = 64'(s.key) << 59; walk_fault = s.wf; vaddr = s.va;
        ukey_reg = s.ukey; skey_reg = s.skey;
        req_valid = 1'b1;
        sb_q.push_back(model(s, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic stim_t base();
        stim_t s;
        s = '{acc: 2'd0, usr: 1'b0, smap: 1'b0, wp: 1'b0, smep: 1'b0, nxe: 1'b0,
              pke: 1'b0, pks: 1'b0, a_usr: 1'b1, a_rw: 1'b1, a_nx: 1'b0, key: 4'd3,
              wf: 2'd0, va: 64'h0000_7f00_1234_5678, ukey: 32'd0, skey: 32'd0};
        return s;
    endfunction

    // Monitor: one expected entry per response, sampled on falling edges.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            total++;
            if (sb_q.size() == 0) begin
                bad++;
                $display("FAIL R11: response with empty queue, got valid=%0d expected 0", rsp_valid);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rsp_grant !== e.grant || rsp_fault !== !e.grant || rsp_prot !== e.prot ||
                    rsp_ecode !== e.ec || rsp_fault_addr !== e.fa) begin
                    bad++;
                    $display("FAIL %s: got g=%0d f=%0d prot=%03b ec=%02h fa=%h exp g=%0d prot=%03b ec=%02h fa=%h",
                             e.tag, rsp_grant, rsp_fault, rsp_prot, rsp_ecode, rsp_fault_addr,
                             e.grant, e.prot, e.ec, e.fa);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        // R11: reset state
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R11: reset valid got %0d expected 0", rsp_valid);
        end
        rst = 1'b0;

        // R1: user access to supervisor page
        s = base(); s.usr = 1; s.a_usr = 0; send(s, "R1");
        s = base(); s.usr = 1; s.a_usr = 0; s.acc = 2'd1; s.va = 64'h1000; send(s, "R1");
        // R2: read blocked by SMAP for supervisor on user page
        s = base(); s.smap = 1; send(s, "R2");
        s = base(); send(s, "R2");
        s = base(); s.smap = 1; s.usr = 1; send(s, "R2");
        // R3: write rules
        s = base(); s.acc = 2'd1; s.a_rw = 0; send(s, "R3");
        s = base(); s.acc = 2'd1; s.a_rw = 0; s.wp = 1; send(s, "R3");
        s = base(); s.acc = 2'd1; s.a_rw = 0; s.usr = 1; send(s, "R3");
        // R4: execute rules
        s = base(); s.acc = 2'd2; s.smep = 1; send(s, "R4");
        s = base(); s.acc = 2'd2; s.smep = 1; s.usr = 1; send(s, "R4");
        s = base(); s.acc = 2'd2; s.a_nx = 1; s.usr = 1; s.nxe = 1; send(s, "R4");
        s = base(); s.acc = 2'd2; s.a_usr = 0; s.smep = 1; send(s, "R4");
        // R5: key register selection
        s = base(); s.usr = 1; s.ukey = 32'h40; send(s, "R5");
        s = base(); s.usr = 1; s.ukey = 32'h40; s.pke = 1; send(s, "R5");
        s = base(); s.a_usr = 0; s.ukey = 32'h40; s.pke = 1; send(s, "R5");
        s = base(); s.a_usr = 0; s.skey = 32'h40; s.pks = 1; send(s, "R5");
        s = base(); s.usr = 1; s.skey = 32'h40; s.pks = 1; send(s, "R5");
        // R6: access and write disable per key
        s = base(); s.usr = 1; s.acc = 2'd1; s.pke = 1; s.ukey = 32'h80; send(s, "R6");
        s = base(); s.usr = 1; s.pke = 1; s.ukey = 32'h80; send(s, "R6");
        s = base(); s.a_usr = 0; s.acc = 2'd1; s.pks = 1; s.skey = 32'h80; send(s, "R6");
        s = base(); s.a_usr = 0; s.acc = 2'd1; s.pks = 1; s.skey = 32'h80; s.wp = 1; send(s, "R6");
        s = base(); s.usr = 1; s.pke = 1; s.key = 4'd15; s.ukey = 32'h4000_0000; send(s, "R6");
        s = base(); s.usr = 1; s.pke = 1; s.key = 4'd0; s.ukey = 32'h4000_0000; send(s, "R6");
        // R7: fetch unaffected by key rule
        s = base(); s.usr = 1; s.acc = 2'd2; s.pke = 1; s.ukey = 32'hFFFF_FFFF; send(s, "R7");
        s = base(); s.usr = 1; s.acc = 2'd0; s.pke = 1; s.ukey = 32'hFFFF_FFFF; send(s, "R7");
        // R8: walker faults
        s = base(); s.wf = 2'd1; s.usr = 1; s.acc = 2'd1; send(s, "R8");
        s = base(); s.wf = 2'd2; send(s, "R8");
        s = base(); s.wf = 2'd3; s.usr = 1; s.a_usr = 0; send(s, "R8");
        // R9: I/D bit conditions
        s = base(); s.acc = 2'd2; s.a_nx = 1; send(s, "R9");
        s = base(); s.acc = 2'd2; s.a_nx = 1; s.nxe = 1; send(s, "R9");
        s = base(); s.acc = 2'd2; s.wf = 2'd1; s.smep = 1; s.usr = 1; send(s, "R9");
        // R10: address reporting
        s = base(); s.wf = 2'd1; s.va = 64'hFFFF_8000_DEAD_B000; send(s, "R10");
        s = base(); s.va = 64'hFFFF_8000_DEAD_B000; send(s, "R10");
        idle();
        @(negedge clk);
        // R11: idle gives no response
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R11: idle valid got %0d expected 0", rsp_valid);
        end
        // R12: mixed sweep
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            s.acc = (a[1:0] == 2'd3) ? 2'd0 : a[1:0];
            s.usr = a[2]; s.smap = a[3]; s.wp = a[4]; s.smep = a[5]; s.nxe = a[6];
            s.pke = a[7]; s.pks = a[8]; s.a_usr = a[9]; s.a_rw = a[10]; s.a_nx = a[11];
            s.key = a[15:12]; s.wf = (a[19:16] == 4'd0) ? a[21:20] : 2'd0;
            s.va = {a, b}; s.ukey = a[22] ? b : 32'd0; s.skey = a[23] ? ~b : 32'd0;
            send(s, "R12");
            if (a[24] && a[25]) idle();
        end
        idle();
        repeat (3) @(negedge clk);
        total++;
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL R11: leftover expected got %0d expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule